// File: doc/BRIEF.md
# Serial-Commanded Eight-Channel Switch Controller

This block is the digital control core of an eight-channel low-side switch. A host writes a one-byte command over a four-wire serial link. While the command shifts in, the host receives a one-byte diagnostic word. When the chip-enable returns high after a complete byte, the command moves into an output latch that drives the eight channel gates.

Channels 0 and 1 also have a direct drive input that is ORed with their latch bit, so a PWM source can drive them without serial traffic.

Each channel has a protective latch that turns the output off after a persistent fault:
- Channels 0 to 5 latch off on an out-of-saturation indication.
- Channels 6 and 7 latch off on an over-temperature indication.

A channel's latch is released by commanding that channel off. An external active-low reset and an active-high low-voltage reset clear all state.

All serial pins and fault pins are sampled with the block clock through synchronizers. The serial clock must therefore run well below the block clock.

Top module: `octal_switch_ctrl`

## Requirements
- R1: The serial word bit order is fixed. The first bit received (bit 7 of the word) is channel 1, followed by channels 3, 5, 7, 0, 2, 4 and 6, so the last bit received (bit 0) is channel 6. For example, a word of 0x80 commands channel 1 only, and 0x01 commands channel 6 only.
- R2: Frame timing:
  - Shifting happens only while csN is low.
  - mosi is sampled on the rising sck edge, most significant bit first.
  - miso presents bit 7 of the diagnostic word from the start of the frame and advances one bit on each falling sck edge.
- R3: The output latch is loaded when csN rises, and only if exactly 8 rising sck edges were seen in the frame. A frame of 7 or 9 edges leaves every output unchanged.
- R4: Channels 0 and 1 are on when their latch bit or their directIn bit is 1, unless the channel's protective latch is set.
- R5: Channels 2 to 7 are on exactly when their latch bit is 1 and their protective latch is clear.
- R6: On channels 0 to 5, satFault held for 4 consecutive clocks sets the protective latch and forces the channel off. A pulse of 3 clocks has no effect.
- R7: On channels 6 and 7, overTemp held for 4 consecutive clocks sets the protective latch. satFault on these channels never affects their output.
- R8: A committed command bit of 0 clears that channel's protective latch. A command bit of 1 alone leaves a set latch set.
- R9: Diagnostic word content:
  - It uses the R1 bit order and is captured when csN falls. miso is 0 while csN is high.
  - For channels 2 to 7, the bit is 1 when the protective latch is set.
  - For channels 0 and 1, the direct input controls the channel when directIn is 1 and the latch bit is 0. In that case the bit reports the protective latch. Otherwise it reports the output state (1 = on).
- R10: rstN low or lowVoltRst high clears the output latch and all protective latches, turning every channel off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Common reset, active low, asynchronous |
| lowVoltRst | input | 1 | Low-voltage reset, active high, asynchronous |
| sck | input | 1 | Serial clock, idles low |
| csN | input | 1 | Serial chip-enable, active low |
| mosi | input | 1 | Serial command data in |
| miso | output | 1 | Serial diagnostic data out |
| directIn | input | 2 | Direct drive for channels 0 and 1 |
| satFault | input | 8 | Out-of-saturation indication, one per channel |
| overTemp | input | 2 | Over-temperature indication for channels 6 and 7 |
| chanOut | output | 8 | Channel gate drive, 1 = on |

## Verification
The bench builds the block with its defaults:
- eight channels, with channels 0 and 1 having direct drive and channels 6 and 7 latching on over-temperature;
- a two-stage synchronizer;
- a four-clock fault filter.

With the short four-clock filter, the 3-clock-rejected and 4-clock-accepted fault pulses sit one clock apart. This lets the bench probe the exact filter boundary.

The two-stage synchronizer keeps the detection latency of csN and sck at three clocks. A serial half-period of six clocks therefore exercises every frame length, the bit-order mapping and the source-dependent diagnostic of channels 0 and 1 within a few thousand cycles.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  localparam int CH_COUNT       = 8;
  localparam int FRAME_BITS     = CH_COUNT;
  localparam int DIRECT_CH      = 2;
  localparam int SAT_LATCH_CH   = 6;
  localparam int TEMP_CH        = CH_COUNT - SAT_LATCH_CH;

  typedef struct packed {
    logic load;     // capture diagnostics into transmit register
    logic rxShift;  // take one command bit
    logic txShift;  // advance transmit register
    logic commit;   // move received word into the output latch
  } spi_strobe_t;

  // word position of a channel: odd channels fill the upper half, even the lower
  function automatic int serialPos(input int ch);
    if (ch % 2 == 1) return CH_COUNT - 1 - (ch - 1) / 2;
    return CH_COUNT / 2 - 1 - ch / 2;
  endfunction
endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/osc_ctrl.sv
module osc_ctrl import swctl_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sck,
  input  logic             csN,
  input  logic             mosi,
  output spi_strobe_t      strobe,
  output logic             mosiBit,
  output logic             csActive,
  output logic [CNT_W-1:0] bitCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [2:0] pinSync;
  logic csS, sckS, csQ, sckQ;

  osc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pinSync (
    .clk(clk), .rstN(rstN), .d({csN, sck, mosi}), .q(pinSync)
  );

  assign csS     = pinSync[2];
  assign sckS    = pinSync[1];
  assign mosiBit = pinSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ  <= 1'b1;
      sckQ <= 1'b0;
    end else begin
      csQ  <= csS;
      sckQ <= sckS;
    end
  end

  assign csActive = !csS;

  always_comb begin
    strobe.load    = csQ && !csS;
    strobe.rxShift = csActive && !sckQ && sckS;
    strobe.txShift = csActive && sckQ && !sckS;
    strobe.commit  = !csQ && csS && (bitCnt == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (strobe.load) bitCnt <= '0;
    else if (strobe.rxShift && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/osc_datapath.sv
module osc_datapath import swctl_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  spi_strobe_t         strobe,
  input  logic                mosiBit,
  input  logic                csActive,
  input  logic [DIRECT_CH-1:0] directIn,
  input  logic [CH_COUNT-1:0] satFault,
  input  logic [TEMP_CH-1:0]  overTemp,
  output logic [CH_COUNT-1:0] chanOut,
  output logic                miso,
  output logic [CH_COUNT-1:0] cmdState,
  output logic [CH_COUNT-1:0] ovlState,
  output logic [CH_COUNT-1:0] faultHit
);
  localparam int FW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [FW-1:0] FILT_TOP = FW'(FILT_LEN - 1);

  logic [CH_COUNT-1:0] satS, newCmd, diag, diagWord, clrMask;
  logic [TEMP_CH-1:0]  tempS;
  logic [CH_COUNT-1:0] rxReg, txReg;

  osc_sync #(.W(CH_COUNT), .STAGES(SYNC_STAGES)) u_satSync (
    .clk(clk), .rstN(rstN), .d(satFault), .q(satS)
  );
  osc_sync #(.W(TEMP_CH), .STAGES(SYNC_STAGES)) u_tempSync (
    .clk(clk), .rstN(rstN), .d(overTemp), .q(tempS)
  );

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_chan
    logic src, drive;
    logic [FW-1:0] runLen;

    if (c < SAT_LATCH_CH) begin : g_sat
      assign src = satS[c];
    end else begin : g_temp
      assign src = tempS[c - SAT_LATCH_CH];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) runLen <= '0;
      else if (!src) runLen <= '0;
      else if (runLen != FILT_TOP) runLen <= runLen + 1'b1;
    end
    assign faultHit[c] = src && (runLen == FILT_TOP);

    if (c < DIRECT_CH) begin : g_direct
      assign drive   = cmdState[c] | directIn[c];
      assign diag[c] = (directIn[c] && !cmdState[c]) ? ovlState[c] : chanOut[c];
    end else begin : g_plain
      assign drive   = cmdState[c];
      assign diag[c] = ovlState[c];
    end

    assign chanOut[c] = drive && !ovlState[c];
    assign newCmd[c]   = rxReg[serialPos(c)];
    assign diagWord[serialPos(c)] = diag[c];
  end

  assign clrMask = strobe.commit ? ~newCmd : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg    <= '0;
      txReg    <= '0;
      cmdState <= '0;
      ovlState <= '0;
    end else begin
      if (strobe.rxShift) rxReg <= {rxReg[CH_COUNT-2:0], mosiBit};
      if (strobe.load) txReg <= diagWord;
      else if (strobe.txShift) txReg <= {txReg[CH_COUNT-2:0], 1'b0};
      if (strobe.commit) cmdState <= newCmd;
      ovlState <= (ovlState | faultHit) & ~clrMask;
    end
  end

  assign miso = csActive && txReg[CH_COUNT-1];
endmodule

// File: rtl/octal_switch_ctrl.sv
module octal_switch_ctrl import swctl_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lowVoltRst,
  input  logic                 sck,
  input  logic                 csN,
  input  logic                 mosi,
  output logic                 miso,
  input  logic [DIRECT_CH-1:0] directIn,
  input  logic [CH_COUNT-1:0]  satFault,
  input  logic [TEMP_CH-1:0]   overTemp,
  output logic [CH_COUNT-1:0]  chanOut
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic rstAllN, mosiBit, csActive, commitPulse;
  logic [CNT_W-1:0] bitCnt;
  logic [CH_COUNT-1:0] cmdState, ovlState, faultHit;
  spi_strobe_t strobe;

  assign rstAllN = rstN && !lowVoltRst;
  assign commitPulse = strobe.commit;

  osc_ctrl #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstAllN), .sck(sck), .csN(csN), .mosi(mosi),
    .strobe(strobe), .mosiBit(mosiBit), .csActive(csActive), .bitCnt(bitCnt)
  );

  osc_datapath #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_dp (
    .clk(clk), .rstN(rstAllN), .strobe(strobe), .mosiBit(mosiBit),
    .csActive(csActive), .directIn(directIn), .satFault(satFault),
    .overTemp(overTemp), .chanOut(chanOut), .miso(miso),
    .cmdState(cmdState), .ovlState(ovlState), .faultHit(faultHit)
  );
endmodule

// File: rtl/octal_switch_ctrl_chk.sv
module octal_switch_ctrl_chk #(
  parameter int N = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          csActive,
  input logic          miso,
  input logic          commit,
  input logic [CW-1:0] bitCnt,
  input logic [N-1:0]  chanOut,
  input logic [N-1:0]  ovl,
  input logic [N-1:0]  hit,
  input logic [N-1:0]  cmd
);
  // R6
  ovl_forces_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanOut & ovl) == '0);

  // R3
  full_frame_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> (bitCnt == CW'(N)));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(cmd));

  // R9
  miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> !miso);

  // R7
  ovl_set_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ovl & ~$past(ovl)) & ~$past(hit)) == '0);
endmodule

bind octal_switch_ctrl octal_switch_ctrl_chk #(.N(CH_COUNT), .CW(CNT_W)) u_chk (
  .clk(clk), .rstN(rstAllN), .csActive(csActive), .miso(miso),
  .commit(commitPulse), .bitCnt(bitCnt), .chanOut(chanOut),
  .ovl(ovlState), .hit(faultHit), .cmd(cmdState)
);

// File: tb/octal_switch_ctrl_bench.sv
module octal_switch_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int NVEC = 7;
  // {channel command, directIn, expected chanOut}
  localparam logic [17:0] VEC [NVEC] = '{
    {8'hFF, 2'b00, 8'hFF},
    {8'h00, 2'b00, 8'h00},
    {8'h00, 2'b01, 8'h01},
    {8'h00, 2'b10, 8'h02},
    {8'hA5, 2'b00, 8'hA5},
    {8'h5A, 2'b11, 8'h5B},
    {8'h0C, 2'b10, 8'h0E}
  };

  logic clk = 0, rstN = 0, lowVoltRst = 0, sck = 0, csN = 1, mosi = 0;
  logic [1:0] directIn = '0, overTemp = '0;
  logic [7:0] satFault = '0;
  logic miso;
  logic [7:0] chanOut, got;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  octal_switch_ctrl u_octal_switch_ctrl (
    .clk(clk), .rstN(rstN), .lowVoltRst(lowVoltRst), .sck(sck), .csN(csN),
    .mosi(mosi), .miso(miso), .directIn(directIn), .satFault(satFault),
    .overTemp(overTemp), .chanOut(chanOut)
  );

  function automatic logic [7:0] toSerial(input logic [7:0] ch);
    return {ch[1], ch[3], ch[5], ch[7], ch[0], ch[2], ch[4], ch[6]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiFrame(input logic [7:0] word, input int nbits, output logic [7:0] rd);
    rd = '0;
    csN = 0;
    waitClk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[(7 - i + 16) % 8];
      waitClk(HALF);
      rd = {rd[6:0], miso};
      sck = 1;
      waitClk(HALF);
      sck = 0;
    end
    waitClk(HALF);
    csN = 1;
    waitClk(2 * HALF);
  endtask

  task automatic writeCh(input logic [7:0] ch);
    spiFrame(toSerial(ch), 8, got);
  endtask

  task automatic pulseSat(input int ch, input int len);
    satFault[ch] = 1;
    waitClk(len);
    satFault[ch] = 0;
    waitClk(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitClk(4);
    check("R10 reset outputs off", chanOut, 8'h00);
    rstN = 1;
    waitClk(4);
    spiFrame(8'h00, 8, got);
    check("R9 diag after reset", got, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      directIn = VEC[v][9:8];
      writeCh(VEC[v][17:10]);
      check("R4 R5 vector table", chanOut, VEC[v][7:0]);
    end
    directIn = '0;

    spiFrame(8'h80, 8, got);
    check("R1 first bit is ch1", chanOut, 8'h02);
    spiFrame(8'h01, 8, got);
    check("R1 last bit is ch6", chanOut, 8'h40);
    spiFrame(8'h10, 8, got);
    check("R1 bit4 is ch7", chanOut, 8'h80);

    writeCh(8'h01);
    writeCh(8'h01);
    check("R9 ch0 status under serial", got, 8'h08);
    check("R2 miso msb-first diag", got, toSerial(8'h01));

    writeCh(8'h00);
    directIn = 2'b01;
    waitClk(2);
    check("R4 direct drives ch0", chanOut, 8'h01);
    pulseSat(0, 6);
    check("R6 ch0 latched off", chanOut, 8'h00);
    writeCh(8'h00);
    check("R9 ch0 fault under direct", got, 8'h08);
    check("R8 clear restores direct ch0", chanOut, 8'h01);
    directIn = '0;

    writeCh(8'h08);
    pulseSat(3, 3);
    check("R6 3-clock pulse ignored", chanOut, 8'h08);
    pulseSat(3, 4);
    check("R6 4-clock pulse latches", chanOut, 8'h00);
    writeCh(8'h08);
    check("R9 ch3 fault bit", got, 8'h40);
    check("R8 write 1 keeps latch", chanOut, 8'h00);
    writeCh(8'h00);
    writeCh(8'h08);
    check("R8 write 0 then 1 re-enables", chanOut, 8'h08);

    writeCh(8'h40);
    pulseSat(6, 10);
    check("R7 satFault ch6 ignored", chanOut, 8'h40);
    overTemp[0] = 1;
    waitClk(4);
    overTemp[0] = 0;
    waitClk(6);
    check("R7 overTemp latches ch6", chanOut, 8'h00);
    writeCh(8'h00);
    check("R9 ch6 fault bit", got, 8'h01);

    spiFrame(8'hFF, 7, got);
    check("R3 7-bit frame dropped", chanOut, 8'h00);
    spiFrame(8'hFF, 9, got);
    check("R3 9-bit frame dropped", chanOut, 8'h00);
    spiFrame(8'hFF, 8, got);
    check("R3 8-bit frame taken", chanOut, 8'hFF);

    writeCh(8'h04);
    pulseSat(2, 5);
    check("R6 ch2 latched", chanOut, 8'h00);
    lowVoltRst = 1;
    waitClk(3);
    check("R10 low-voltage reset off", chanOut, 8'h00);
    lowVoltRst = 0;
    waitClk(4);
    writeCh(8'h04);
    check("R10 low-voltage reset clears latch", chanOut, 8'h04);

    writeCh(8'hFF);
    rstN = 0;
    waitClk(2);
    check("R10 rstN clears outputs", chanOut, 8'h00);
    rstN = 1;
    waitClk(4);
    check("R10 stays off after reset", chanOut, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule